// File: doc/BRIEF.md
# Full-Bridge Resonant Drive Sequencer

This block turns a digital half-period command into the four gate commands of an H-bridge that excites a resonant tank. Each half-cycle drives one diagonal of the bridge (high side of one leg with low side of the other), starting after a programmable dead time and lasting for an on-time taken from a duty input, with a hard ceiling near 45% of the half-cycle. The switching rate is carried as a half-period length in clock cycles, so a larger word means a lower frequency.

After enable the block runs a startup sweep: it begins at the half-period that gives the highest allowed frequency and lengthens the half-period one cycle at a time until a "struck" input reports that the load has ignited. The sweep never goes past the point where the frequency is about 85% of the maximum. From then on the external command is followed, clamped to the same window. An over-voltage input forces the maximum frequency while it is high. Each leg has a current-limit input that cuts off only the active low-side switch of that leg for the rest of the half-cycle, once a leading-edge blanking window has passed. An enable input (shutdown, undervoltage or latched fault) and a burst gate from the dimming logic both force all four outputs off.

Top module: `fbr_drive_seq`

## Requirements
- R1: While `en` is low at a rising edge, all four outputs are low after that edge and the sweep restarts; the first edge with `en` high starts a half-cycle on diagonal A (`gh_a` with `gl_b`) whose half-period is `hp_max`.
- R2: Half-cycles alternate between diagonal A (`gh_a`, `gl_b`) and diagonal B (`gh_b`, `gl_a`); each half-cycle lasts the half-period word latched at its first edge.
- R3: In every half-cycle all four outputs stay low for the first `dead` cycles.
- R4: The on-time after the dead time equals min(floor(hp*duty/256), floor(hp*115/256)) cycles, where hp is the latched half-period, so it never exceeds 45% of the half-cycle.
- R5: During the sweep the half-period starts at `hp_max` and grows by one every 16 cycles (parameter), never beyond the ceiling hp_max + floor(hp_max*45/256), which keeps the frequency at or above 85% of the maximum.
- R6: Once `struck` is seen high the sweep ends and the half-period follows `hp_cmd` clamped to [hp_max, ceiling]; this holds until `en` goes low, even if `struck` falls.
- R7: While `ovp` is high the half-period latched at each half-cycle start is `hp_max`, and the sweep does not advance.
- R8: In a diagonal A half-cycle `ilim_b` turns off `gl_b` only, and in a diagonal B half-cycle `ilim_a` turns off `gl_a` only; the cut lasts to the end of that half-cycle and the high-side switch keeps its full on-time.
- R9: A current-limit input is acted on only at edges where the half-cycle cycle count is at least `dead` + 37 (about 370 ns at a 100 MHz clock); the input of the leg whose low side is idle is ignored.
- R10: While `burst` is low at a rising edge, all four outputs are low after that edge; the half-cycle timing keeps running underneath.
- R11: A high-side and low-side switch of the same leg are never on together, and the two diagonals are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all outputs off and restarts the sweep |
| burst | input | 1 | Burst gate from dimming logic; low blanks the outputs |
| struck | input | 1 | Load has ignited; ends the sweep |
| ovp | input | 1 | Over-voltage; forces the maximum frequency |
| hp_max | input | 12 | Half-period in cycles at the maximum frequency (held static while enabled) |
| hp_cmd | input | 12 | Half-period command used after the sweep |
| duty | input | 8 | Requested on-time as a fraction of 256 of the half-cycle |
| dead | input | 4 | Dead time in cycles at the start of each half-cycle |
| ilim_a | input | 1 | Current-limit flag of leg A |
| ilim_b | input | 1 | Current-limit flag of leg B |
| gh_a | output | 1 | High-side gate command, leg A |
| gl_a | output | 1 | Low-side gate command, leg A |
| gh_b | output | 1 | High-side gate command, leg B |
| gl_b | output | 1 | Low-side gate command, leg B |

## Verification
The bench aims at the edges of the on-time: a full duty request must be cut to the 45% ceiling, and a design that skipped the clamp would hold the diagonal on for nearly the whole half-cycle. It drives the half-period command below and above the allowed window and holds the sweep long enough to reach the ceiling; a missing clamp would show up as a period shorter than the maximum-frequency one or longer than the 85% limit. Current-limit flags are applied to each leg in turn and at random, so a design that cut the wrong leg, cut the high side, or honoured the flag inside the blanking window would show a wrong low-side pulse width. Restarting after a disable checks that a design which kept its sweep or tracking state would begin at the wrong half-period.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    // Which diagonal of the bridge conducts in a half-cycle.
    typedef enum logic {
        DIAG_HA_LB = 1'b0,   // high side of leg A with low side of leg B
        DIAG_HB_LA = 1'b1    // high side of leg B with low side of leg A
    } diag_e;

    // Fixed-point fractions in 1/256 units.
    localparam int unsigned FRAC_SH   = 8;
    localparam int unsigned CLAMP_NUM = 115;  // 115/256 < 0.45 on-time ceiling
    localparam int unsigned CEIL_NUM  = 45;   // 1 + 45/256 < 1/0.85 half-period ceiling

    // Longest half-period the sweep or command may reach.
    function automatic int unsigned ceil_half_period(input int unsigned hp_max);
        return hp_max + ((hp_max * CEIL_NUM) >> FRAC_SH);
    endfunction

    // On-time for a half-period and duty request, with the hard ceiling applied.
    function automatic int unsigned on_time(input int unsigned hp,
                                            input int unsigned duty,
                                            input int          duty_bits);
        int unsigned req;
        int unsigned cap;
        req = (hp * duty) >> duty_bits;
        cap = (hp * CLAMP_NUM) >> FRAC_SH;
        return (req < cap) ? req : cap;
    endfunction

endpackage

// File: rtl/fbr_sweep.sv
module fbr_sweep
    import fbr_pkg::*;
#(
    parameter int HP_W     = 12,
    parameter int STEP_CYC = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            struck,
    input  logic            ovp,
    input  logic [HP_W-1:0] hp_max,
    input  logic [HP_W-1:0] hp_cmd,
    output logic [HP_W:0]   hp_eff
);
    localparam int HPI_W  = HP_W + 1;
    localparam int STEP_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    logic [HPI_W-1:0]  sweep_hp;
    logic [HPI_W-1:0]  base_hp;
    logic [HPI_W-1:0]  ceil_hp;
    logic [HPI_W-1:0]  cmd_hp;
    logic [HPI_W-1:0]  cmd_clamped;
    logic              tracking;
    logic [STEP_W-1:0] step_cnt;

    assign base_hp = {1'b0, hp_max};
    assign cmd_hp  = {1'b0, hp_cmd};
    assign ceil_hp = HPI_W'(ceil_half_period(32'(hp_max)));

    always_comb begin
        if (cmd_hp < base_hp)
            cmd_clamped = base_hp;
        else if (cmd_hp > ceil_hp)
            cmd_clamped = ceil_hp;
        else
            cmd_clamped = cmd_hp;
    end

    always_comb begin
        if (ovp)
            hp_eff = base_hp;
        else if (tracking)
            hp_eff = cmd_clamped;
        else
            hp_eff = sweep_hp;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sweep_hp <= base_hp;
            tracking <= 1'b0;
            step_cnt <= '0;
        end else if (!tracking) begin
            if (struck) begin
                tracking <= 1'b1;
            end else if (!ovp) begin
                if (step_cnt == STEP_W'(STEP_CYC - 1)) begin
                    step_cnt <= '0;
                    if (sweep_hp < ceil_hp)
                        sweep_hp <= sweep_hp + 1'b1;
                end else begin
                    step_cnt <= step_cnt + 1'b1;
                end
            end
        end
    end

    AST_SWEEP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (sweep_hp >= base_hp) && (sweep_hp <= ceil_hp))
        else $error("sweep left its window"); // R5

    AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && tracking) |=> tracking)
        else $error("tracking dropped while enabled"); // R6

    AST_OVP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (en && ovp && !tracking) |=> $stable(sweep_hp))
        else $error("sweep moved under over-voltage"); // R7

endmodule

// File: rtl/fbr_halfcycle.sv
module fbr_halfcycle
    import fbr_pkg::*;
#(
    parameter int HP_W      = 12,
    parameter int DUTY_W    = 8,
    parameter int DEAD_W    = 4,
    parameter int BLANK_CYC = 37
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              burst,
    input  logic [HP_W:0]     hp_eff,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DEAD_W-1:0] dead,
    input  logic              ilim_a,
    input  logic              ilim_b,
    output logic              active,
    output diag_e             diag,
    output logic              lo_kill
);
    localparam int HPI_W = HP_W + 1;
    localparam int WIN_W = HPI_W + 1;

    typedef struct packed {
        logic [HPI_W-1:0] hp;
        logic [HPI_W-1:0] ton;
    } slot_t;

    slot_t            slot;
    slot_t            slot_nx;
    logic             run;
    logic             burst_q;
    logic             kill;
    logic [HPI_W-1:0] cnt;
    logic [WIN_W-1:0] cnt_w;
    logic [WIN_W-1:0] dead_w;
    logic [WIN_W-1:0] win_end;
    logic [WIN_W-1:0] blank_end;
    logic             wrap;
    logic             leg_lim;

    assign slot_nx.hp  = hp_eff;
    assign slot_nx.ton = HPI_W'(on_time(32'(hp_eff), 32'(duty), DUTY_W));

    assign cnt_w     = {1'b0, cnt};
    assign dead_w    = WIN_W'(dead);
    assign win_end   = dead_w + {1'b0, slot.ton};
    assign blank_end = dead_w + WIN_W'(BLANK_CYC);
    assign wrap      = !run || (cnt == slot.hp - 1'b1);
    assign leg_lim   = (diag == DIAG_HA_LB) ? ilim_b : ilim_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            burst_q <= 1'b0;
            cnt     <= '0;
            diag    <= DIAG_HA_LB;
            slot    <= '0;
            kill    <= 1'b0;
        end else begin
            burst_q <= burst;
            if (!en) begin
                run  <= 1'b0;
                cnt  <= '0;
                kill <= 1'b0;
                diag <= DIAG_HA_LB;
            end else begin
                run <= 1'b1;
                if (wrap) begin
                    cnt  <= '0;
                    slot <= slot_nx;
                    kill <= 1'b0;
                    if (run && diag == DIAG_HA_LB)
                        diag <= DIAG_HB_LA;
                    else
                        diag <= DIAG_HA_LB;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (cnt_w >= blank_end && leg_lim)
                        kill <= 1'b1;
                end
            end
        end
    end

    assign active  = run && burst_q && (cnt_w >= dead_w) && (cnt_w < win_end);
    assign lo_kill = kill;

    AST_TON_CLAMP: assert property (@(posedge clk) disable iff (rst)
        ((32'(slot.ton) << 8) <= (32'(slot.hp) * 32'd115)))
        else $error("on-time above ceiling"); // R4

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        ((dead != '0) && (diag != $past(diag))) |-> !active)
        else $error("diagonal switched without dead time"); // R3

    AST_BLANK_HONOURED: assert property (@(posedge clk) disable iff (rst)
        $rose(kill) |-> ($past(cnt) >= HPI_W'(BLANK_CYC)))
        else $error("current limit taken inside blanking"); // R9

    AST_KILL_PER_HALF: assert property (@(posedge clk) disable iff (rst)
        $fell(kill) |-> ((cnt == '0) || !run))
        else $error("cut released inside a half-cycle"); // R8

endmodule

// File: rtl/fbr_gate_map.sv
module fbr_gate_map
    import fbr_pkg::*;
(
    input  logic  active,
    input  diag_e diag,
    input  logic  lo_kill,
    output logic  gh_a,
    output logic  gl_a,
    output logic  gh_b,
    output logic  gl_b
);
    logic on_a;
    logic on_b;

    assign on_a = active && (diag == DIAG_HA_LB);
    assign on_b = active && (diag == DIAG_HB_LA);

    assign gh_a = on_a;
    assign gl_b = on_a && !lo_kill;
    assign gh_b = on_b;
    assign gl_a = on_b && !lo_kill;

endmodule

// File: rtl/fbr_drive_seq.sv
module fbr_drive_seq
    import fbr_pkg::*;
#(
    parameter int HP_W      = 12,
    parameter int DUTY_W    = 8,
    parameter int DEAD_W    = 4,
    parameter int BLANK_CYC = 37,
    parameter int STEP_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              burst,
    input  logic              struck,
    input  logic              ovp,
    input  logic [HP_W-1:0]   hp_max,
    input  logic [HP_W-1:0]   hp_cmd,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DEAD_W-1:0] dead,
    input  logic              ilim_a,
    input  logic              ilim_b,
    output logic              gh_a,
    output logic              gl_a,
    output logic              gh_b,
    output logic              gl_b
);
    logic [HP_W:0] hp_eff;
    logic          active;
    diag_e         diag;
    logic          lo_kill;

    fbr_sweep #(
        .HP_W     (HP_W),
        .STEP_CYC (STEP_CYC)
    ) u_sweep (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .struck (struck),
        .ovp    (ovp),
        .hp_max (hp_max),
        .hp_cmd (hp_cmd),
        .hp_eff (hp_eff)
    );

    fbr_halfcycle #(
        .HP_W      (HP_W),
        .DUTY_W    (DUTY_W),
        .DEAD_W    (DEAD_W),
        .BLANK_CYC (BLANK_CYC)
    ) u_half (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .burst   (burst),
        .hp_eff  (hp_eff),
        .duty    (duty),
        .dead    (dead),
        .ilim_a  (ilim_a),
        .ilim_b  (ilim_b),
        .active  (active),
        .diag    (diag),
        .lo_kill (lo_kill)
    );

    fbr_gate_map u_map (
        .active  (active),
        .diag    (diag),
        .lo_kill (lo_kill),
        .gh_a    (gh_a),
        .gl_a    (gl_a),
        .gh_b    (gh_b),
        .gl_b    (gl_b)
    );

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        !(gh_a && gl_a) && !(gh_b && gl_b))
        else $error("same-leg overlap"); // R11

    AST_DIAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((gh_a || gl_b) && (gh_b || gl_a)))
        else $error("both diagonals on"); // R11

    AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> !(gh_a || gl_a || gh_b || gl_b))
        else $error("output on while disabled"); // R1

    AST_BURST_OFF: assert property (@(posedge clk) disable iff (rst)
        !burst |=> !(gh_a || gl_a || gh_b || gl_b))
        else $error("output on outside burst"); // R10

    AST_LOW_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (gl_b |-> gh_a) and (gl_a |-> gh_b))
        else $error("low side on without its diagonal partner"); // R8

endmodule

// File: tb/fbr_drive_seq_test.sv
module fbr_drive_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int BLANK      = 37;
    localparam int STEP       = 16;

    logic        clk = 1'b0;
    logic        rst, en, burst, struck, ovp, ilim_a, ilim_b;
    logic [11:0] hp_max, hp_cmd;
    logic [7:0]  duty;
    logic [3:0]  dead;
    logic        gh_a, gl_a, gh_b, gl_b;

    fbr_drive_seq uut (
        .clk(clk), .rst(rst), .en(en), .burst(burst), .struck(struck), .ovp(ovp),
        .hp_max(hp_max), .hp_cmd(hp_cmd), .duty(duty), .dead(dead),
        .ilim_a(ilim_a), .ilim_b(ilim_b),
        .gh_a(gh_a), .gl_a(gl_a), .gh_b(gh_b), .gl_b(gl_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_run, m_cnt, m_phase, m_hp, m_ton, m_kill, m_burst;
    int m_sw, m_trk, m_step, m_eff, m_lim;

    function automatic int b_ceil(input int mx);
        return mx + (mx * 45) / 256;
    endfunction

    function automatic int b_clamp(input int cmd, input int mx);
        if (cmd < mx) return mx;
        if (cmd > b_ceil(mx)) return b_ceil(mx);
        return cmd;
    endfunction

    function automatic int b_ton(input int hp, input int d);
        int req, cap;
        req = (hp * d) / 256;
        cap = (hp * 115) / 256;
        return (req < cap) ? req : cap;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_cnt = 0; m_phase = 0; m_hp = 0; m_ton = 0; m_kill = 0;
            m_burst = 0; m_sw = int'(hp_max); m_trk = 0; m_step = 0;
        end else begin
            m_burst = int'(burst);
            m_lim   = b_ceil(int'(hp_max));
            if (!en) begin
                m_run = 0; m_cnt = 0; m_kill = 0; m_phase = 0;
                m_sw = int'(hp_max); m_trk = 0; m_step = 0;
            end else begin
                if (ovp) m_eff = int'(hp_max);
                else if (m_trk != 0) m_eff = b_clamp(int'(hp_cmd), int'(hp_max));
                else m_eff = m_sw;
                if (m_run == 0 || m_cnt == m_hp - 1) begin
                    m_phase = (m_run != 0) ? 1 - m_phase : 0;
                    m_cnt = 0; m_hp = m_eff; m_ton = b_ton(m_eff, int'(duty)); m_kill = 0;
                end else begin
                    if (m_cnt >= int'(dead) + BLANK && ((m_phase == 0) ? ilim_b : ilim_a))
                        m_kill = 1;
                    m_cnt++;
                end
                m_run = 1;
                if (m_trk == 0) begin
                    if (struck) m_trk = 1;
                    else if (!ovp) begin
                        if (m_step == STEP - 1) begin
                            m_step = 0;
                            if (m_sw < m_lim) m_sw++;
                        end else m_step++;
                    end
                end
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int e_on, e_a, e_b;
            e_on = (m_run != 0 && m_burst != 0 && m_cnt >= int'(dead) &&
                    m_cnt < int'(dead) + m_ton) ? 1 : 0;
            e_a = (e_on != 0 && m_phase == 0) ? 1 : 0;
            e_b = (e_on != 0 && m_phase == 1) ? 1 : 0;
            chk("R4 gh_a per-cycle", int'(gh_a), e_a);
            chk("R4 gh_b per-cycle", int'(gh_b), e_b);
            chk("R8 gl_b per-cycle", int'(gl_b), (e_a != 0 && m_kill == 0) ? 1 : 0);
            chk("R8 gl_a per-cycle", int'(gl_a), (e_b != 0 && m_kill == 0) ? 1 : 0);
            chk("R11 no overlap", int'((gh_a && gl_a) || (gh_b && gl_b) ||
                ((gh_a || gl_b) && (gh_b || gl_a))), 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000 && !done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int get(input int idx);
        case (idx)
            0: return int'(gh_a);
            1: return int'(gl_a);
            2: return int'(gh_b);
            default: return int'(gl_b);
        endcase
    endfunction

    // Width of the first high run after a rise, and rise-to-rise distance.
    task automatic measure(input int idx, output int on_len, output int per);
        int prev, cur, guard;
        bit first;
        on_len = -1; per = -1; guard = 0;
        prev = get(idx);
        forever begin
            @(negedge clk);
            cur = get(idx); guard++;
            if (cur != 0 && prev == 0) break;
            prev = cur;
            if (guard > 3000) return;
        end
        on_len = 1; per = 1; first = 1; prev = 1;
        forever begin
            @(negedge clk);
            cur = get(idx); guard++;
            if (cur != 0 && prev == 0) break;
            if (cur == 0) first = 0;
            if (cur != 0 && first) on_len++;
            per++;
            prev = cur;
            if (guard > 6000) begin per = -1; return; end
        end
    endtask

    task automatic all_off(input string tag);
        chk(tag, int'(gh_a) + int'(gl_a) + int'(gh_b) + int'(gl_b), 0);
    endtask

    int on_len, per;
    logic [15:0] lfsr = 16'hACE1;

    initial begin
        rst = 1; en = 0; burst = 1; struck = 0; ovp = 0; ilim_a = 0; ilim_b = 0;
        hp_max = 12'd200; hp_cmd = 12'd210; duty = 8'd255; dead = 4'd3;
        step(5);
        rst = 0;
        step(2);
        all_off("R1 reset and disabled");

        // Start-up: first half-cycle on diagonal A with hp 200, ton 89.
        en = 1;
        step(1);  all_off("R3 dead cycle 0");
        step(2);  all_off("R3 dead cycle 2");
        step(1);
        chk("R2 gh_a on at cycle 3", int'(gh_a), 1);
        chk("R2 gl_b on at cycle 3", int'(gl_b), 1);
        chk("R2 gh_b off in diag A", int'(gh_b), 0);
        step(88); chk("R4 gh_a last clamped cycle", int'(gh_a), 1);
        step(1);  chk("R4 gh_a off after 89 cycles", int'(gh_a), 0);
        step(110); chk("R2 gh_b before second dead time ends", int'(gh_b), 0);
        step(1);
        chk("R2 gh_b on in second half", int'(gh_b), 1);
        chk("R2 gl_a on in second half", int'(gl_a), 1);
        chk("R2 gh_a off in second half", int'(gh_a), 0);

        // Sweep reaches its ceiling 235.
        step(1200);
        measure(0, on_len, per);
        chk("R5 period at sweep ceiling", per, 470);
        chk("R4 clamped on-time at 235", on_len, 105);
        duty = 8'd64;
        measure(0, on_len, per);
        measure(0, on_len, per);
        chk("R4 duty-limited on-time", on_len, 58);

        // Tracking the command.
        struck = 1;
        step(1000);
        measure(0, on_len, per);
        chk("R6 tracked period", per, 420);
        chk("R4 on-time at 210", on_len, 52);
        hp_cmd = 12'd100;
        step(600);
        measure(0, on_len, per);
        chk("R6 command clamped to hp_max", per, 400);
        hp_cmd = 12'd4000;
        step(600);
        measure(0, on_len, per);
        chk("R6 command clamped to ceiling", per, 470);
        struck = 0; hp_cmd = 12'd210;
        step(600);
        measure(0, on_len, per);
        chk("R6 tracking kept after struck falls", per, 420);

        // Over-voltage.
        ovp = 1;
        step(600);
        measure(0, on_len, per);
        chk("R7 period forced to maximum frequency", per, 400);
        ovp = 0;
        step(600);
        measure(0, on_len, per);
        chk("R7 period back after release", per, 420);

        // Current limit on each leg; ton at 210 is 94.
        duty = 8'd255; ilim_b = 1;
        step(600);
        measure(3, on_len, per);
        chk("R9 gl_b cut after blanking", on_len, 38);
        measure(0, on_len, per);
        chk("R8 gh_a keeps full on-time", on_len, 94);
        measure(1, on_len, per);
        chk("R9 idle-leg limit ignored on gl_a", on_len, 94);
        ilim_b = 0; ilim_a = 1;
        step(600);
        measure(1, on_len, per);
        chk("R8 gl_a cut after blanking", on_len, 38);
        measure(3, on_len, per);
        chk("R8 gl_b untouched by ilim_a", on_len, 94);
        ilim_a = 0;

        // Burst gate.
        step(300);
        burst = 0;
        step(1); all_off("R10 burst low blanks outputs");
        step(300); all_off("R10 outputs stay off in burst gap");
        burst = 1;
        step(300);
        measure(0, on_len, per);
        chk("R10 timing continued under burst gap", per, 420);

        // Random stress, compared cycle by cycle.
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ilim_a = lfsr[0] & lfsr[3];
            ilim_b = lfsr[5] & lfsr[7];
            burst  = !(lfsr[2] & lfsr[9] & lfsr[11]);
            ovp    = lfsr[4] & lfsr[8] & lfsr[12] & lfsr[14];
            if (i % 256 == 0) duty = lfsr[15:8];
            step(1);
        end

        // Disable and restart: sweep and tracking restart from hp_max.
        en = 0; ilim_a = 0; ilim_b = 0; ovp = 0; burst = 1; duty = 8'd255;
        step(1); all_off("R1 outputs off after en falls");
        step(2); all_off("R1 outputs stay off while disabled");
        en = 1;
        step(1); all_off("R1 restart dead cycle");
        step(3);
        chk("R1 restart on diagonal A", int'(gh_a), 1);
        chk("R1 restart gl_b on", int'(gl_b), 1);
        step(199); chk("R1 first half still 200 long", int'(gh_b), 0);
        step(1);   chk("R5 restart half-period is hp_max", int'(gh_b), 1);
        step(1200);
        measure(0, on_len, per);
        chk("R5 sweep ceiling after restart", per, 470);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule